// File: doc/BRIEF.md
# Asynchronous Serial Framer with Raw Ninth Bit

This block sends and receives asynchronous serial characters on a single output line and a single input line. Software picks a word of 7 or 8 data bits and can add one extra bit after the data. The block neither generates nor checks parity on that bit. On the transmit side it is sent as written. On the receive side it is captured and kept alongside the data byte it arrived with. Bit timing comes from a 4-bit divisor code over a 16x oversampling clock. One bit lasts 16*(code+1) system clocks.

The receive side brings the line into the clock domain and detects the falling edge of a start bit. It confirms the start bit at its middle and samples every later bit at its centre. Each finished character goes into an 8-entry queue together with its extra bit and a framing-error flag. Software can instead select a single holding register, so that one unread character blocks the next. Configuration is written through a write strobe and read back on dedicated outputs.

Top module: `uart9_top`

## Requirements
- R1: After reset every configuration readback output is 0. A cycle with `cfgWe` high loads all four configuration fields, and the new values appear on the readback outputs on the next cycle.
- R2: `serialOut` idles high. An accepted character is sent as a low start bit, then the data bits least significant first, then a high stop bit. Every bit lasts 16*(`cfgDivOut`+1) clocks. `txBusy` stays high from the accept edge until the stop bit ends.
- R3: With `cfgSevenOut`=1 exactly seven data bits are sent, and `txData[7]` has no effect on the line.
- R4: With `cfgXbitEnOut`=1 the value of `txXbit` is sent unchanged as one bit between the last data bit and the stop bit. With it 0, no such bit is sent and `txXbit` has no effect.
- R5: A received character's data bits, taken least significant first, appear on `rxData`. With `cfgSevenOut`=1, `rxData[7]` reads 0.
- R6: With `cfgXbitEnOut`=1 the bit received after the data appears on `rxXbit` together with that same word. With it 0, `rxXbit` reads 0.
- R7: A character whose stop bit is sampled low is still stored, and its `rxFrameErr` reads 1. A character with a high stop bit reads 0.
- R8: With `cfgFifoOffOut`=0 up to 8 characters are held and read out in arrival order. `rxRead` pops the head word while `rxAvail` is 1. A character that arrives while 8 are held is dropped and sets `rxOverrun`. A read that pops a word clears `rxOverrun`.
- R9: With `cfgFifoOffOut`=1 only one character is held. A character that arrives while it is unread is dropped and sets `rxOverrun`.
- R10: Pulsing `txValid` while `txBusy` is 1 has no effect on the character in flight or on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgDivIn | input | DIV_W | Baud divisor code to write |
| cfgSevenIn | input | 1 | Word length to write: 1 selects 7 bits, 0 selects 8 |
| cfgXbitEnIn | input | 1 | Extra-bit enable to write |
| cfgFifoOffIn | input | 1 | Queue disable to write: 1 selects the single holding register |
| cfgDivOut | output | DIV_W | Divisor code readback |
| cfgSevenOut | output | 1 | Word-length readback |
| cfgXbitEnOut | output | 1 | Extra-bit enable readback |
| cfgFifoOffOut | output | 1 | Queue disable readback |
| txValid | input | 1 | Request to send `txData` and `txXbit` |
| txData | input | 8 | Transmit data byte |
| txXbit | input | 1 | Transmit extra bit |
| txBusy | output | 1 | A character is being sent |
| serialOut | output | 1 | Serial transmit line |
| serialIn | input | 1 | Serial receive line (asynchronous) |
| rxRead | input | 1 | Pop the head received word |
| rxAvail | output | 1 | At least one received word is held |
| rxData | output | 8 | Head word data |
| rxXbit | output | 1 | Head word extra bit |
| rxFrameErr | output | 1 | Head word framing error |
| rxOverrun | output | 1 | A character was dropped since the last pop |

## Verification
The transmit line is compared every clock against a timing model. The model covers 8-bit frames, 7-bit frames with an all-ones byte (to show the top bit is ignored), and frames with the extra bit both enabled and disabled. A second request is issued in the middle of a frame to show it is ignored. On the receive side, frames are driven in both word lengths and with the extra bit on and off. A 7-bit frame carries a zero extra bit where bit 7 would sit, which separates data placement from extra-bit capture. A low stop bit followed by a clean frame shows the error flag stays with its own word. Nine back-to-back frames into the queue, and two into the single register, tell the two capacities apart and exercise overrun set and clear.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

  localparam int WORD_W    = 8;
  localparam int FRAME_MAX = 11;   // start + 8 data + extra + stop

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS,
    RX_STOP
  } rxState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic       txLoad;
    logic       txShift;
    logic       rxArm;
    logic       rxSample;
    logic [2:0] rxIdx;
    logic       rxToX;
    logic       rxPush;
    logic       rxStopBad;
  } ctrlStrobes_t;

  typedef struct packed {
    logic              frameErr;
    logic              xbit;
    logic [WORD_W-1:0] data;
  } rxWord_t;

endpackage

// File: rtl/uart9_ctrl.sv
module uart9_ctrl
  import uart9_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgDivIn,
  input  logic             cfgSevenIn,
  input  logic             cfgXbitEnIn,
  input  logic             cfgFifoOffIn,
  output logic [DIV_W-1:0] cfgDiv,
  output logic             cfgSeven,
  output logic             cfgXbitEn,
  output logic             cfgFifoOff,
  input  logic             txValid,
  output logic             txBusy,
  input  logic             lineSync,
  output ctrlStrobes_t     stb
);

  localparam int SUB_W = $clog2(OVS);
  localparam int CNT_W = $clog2(OVS * (1 << DIV_W));
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  // ---------------- configuration register ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgDiv     <= '0;
      cfgSeven   <= 1'b0;
      cfgXbitEn  <= 1'b0;
      cfgFifoOff <= 1'b0;
    end else if (cfgWe) begin
      cfgDiv     <= cfgDivIn;
      cfgSeven   <= cfgSevenIn;
      cfgXbitEn  <= cfgXbitEnIn;
      cfgFifoOff <= cfgFifoOffIn;
    end
  end

  // ---------------- transmit sequencing ----------------
  logic [CNT_W-1:0] bitLenM1;
  logic [3:0]       txFrameBits;
  logic [CNT_W-1:0] txCnt;
  logic [CNT_W-1:0] txLenQ;
  logic [3:0]       txLeft;
  logic             txAccept;
  logic             txBoundary;

  always_comb begin
    bitLenM1    = CNT_W'((int'(cfgDiv) + 1) * OVS - 1);
    txFrameBits = 4'd2 + (cfgSeven ? 4'd7 : 4'd8) + {3'b000, cfgXbitEn};
  end

  assign txAccept   = txValid & ~txBusy;
  assign txBoundary = txBusy & (txCnt == txLenQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txLenQ <= '0;
      txLeft <= '0;
    end else if (txAccept) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
      txLenQ <= bitLenM1;
      txLeft <= txFrameBits - 4'd1;
    end else if (txBusy) begin
      if (txBoundary) begin
        txCnt <= '0;
        if (txLeft == 4'd0) txBusy <= 1'b0;
        else                txLeft <= txLeft - 4'd1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  // ---------------- receive sequencing ----------------
  rxState_t         rxState;
  logic [DIV_W-1:0] rxDivQ;
  logic [DIV_W-1:0] divCnt;
  logic [SUB_W-1:0] subCnt;
  logic [3:0]       bitIdx;
  logic [3:0]       dataNQ;
  logic [3:0]       lastIdxQ;
  logic             linePrev;
  logic             tick;
  logic             falling;
  logic             subEnd;

  assign tick    = (divCnt == rxDivQ);
  assign falling = linePrev & ~lineSync;
  assign subEnd  = tick & (subCnt == SUB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxDivQ   <= '0;
      divCnt   <= '0;
      subCnt   <= '0;
      bitIdx   <= '0;
      dataNQ   <= 4'd8;
      lastIdxQ <= 4'd7;
      linePrev <= 1'b1;
    end else begin
      linePrev <= lineSync;
      if (rxState != RX_IDLE) divCnt <= tick ? '0 : divCnt + 1'b1;
      unique case (rxState)
        RX_IDLE: begin
          if (falling) begin
            rxState  <= RX_START;
            divCnt   <= '0;
            subCnt   <= '0;
            rxDivQ   <= cfgDiv;
            dataNQ   <= cfgSeven ? 4'd7 : 4'd8;
            lastIdxQ <= (cfgSeven ? 4'd6 : 4'd7) + {3'b000, cfgXbitEn};
          end
        end
        RX_START: begin
          if (tick) begin
            if (subCnt == SUB_HALF) begin
              subCnt <= '0;
              bitIdx <= '0;
              rxState <= lineSync ? RX_IDLE : RX_BITS;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (subCnt == SUB_LAST) begin
              subCnt <= '0;
              if (bitIdx == lastIdxQ) rxState <= RX_STOP;
              else                    bitIdx  <= bitIdx + 4'd1;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (subCnt == SUB_LAST) begin
              subCnt  <= '0;
              rxState <= RX_IDLE;
            end else begin
              subCnt <= subCnt + 1'b1;
            end
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- strobes to the datapath ----------------
  always_comb begin
    stb           = '0;
    stb.txLoad    = txAccept;
    stb.txShift   = txBoundary;
    stb.rxArm     = (rxState == RX_IDLE) & falling;
    stb.rxSample  = (rxState == RX_BITS) & subEnd;
    stb.rxIdx     = bitIdx[2:0];
    stb.rxToX     = (bitIdx == dataNQ);
    stb.rxPush    = (rxState == RX_STOP) & subEnd;
    stb.rxStopBad = ~lineSync;
  end

endmodule

// File: rtl/uart9_dp.sv
module uart9_dp
  import uart9_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic              cfgSeven,
  input  logic              cfgXbitEn,
  input  logic              cfgFifoOff,
  input  logic [WORD_W-1:0] txData,
  input  logic              txXbit,
  output logic              serialOut,
  input  logic              serialIn,
  output logic              lineSync,
  input  logic              rxRead,
  output logic              rxAvail,
  output rxWord_t           rxHead,
  output logic              rxOverrun
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // ---------------- input synchroniser ----------------
  logic [SYNC_STAGES-1:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= serialIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], serialIn};
      end
    end
  endgenerate

  assign lineSync = syncQ[SYNC_STAGES-1];

  // ---------------- transmit frame and shifter ----------------
  logic [FRAME_MAX-1:0] txFrame;
  logic [FRAME_MAX-1:0] txSh;

  always_comb begin
    txFrame    = '1;
    txFrame[0] = 1'b0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < WORD_W - 1 || !cfgSeven) txFrame[1 + i] = txData[i];
    end
    if (cfgXbitEn) begin
      if (cfgSeven) txFrame[WORD_W]     = txXbit;
      else          txFrame[WORD_W + 1] = txXbit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txSh <= '1;
    else if (stb.txLoad)  txSh <= txFrame;
    else if (stb.txShift) txSh <= {1'b1, txSh[FRAME_MAX-1:1]};
  end

  assign serialOut = txSh[0];

  // ---------------- receive assembly ----------------
  logic [WORD_W-1:0] accData;
  logic              accX;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accData <= '0;
      accX    <= 1'b0;
    end else if (stb.rxArm) begin
      accData <= '0;
      accX    <= 1'b0;
    end else if (stb.rxSample) begin
      if (stb.rxToX) accX <= lineSync;
      else           accData[stb.rxIdx] <= lineSync;
    end
  end

  // ---------------- receive queue ----------------
  rxWord_t          mem [DEPTH];
  rxWord_t          newWord;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             doPush;
  logic             doPop;

  assign newWord = '{frameErr: stb.rxStopBad, xbit: accX, data: accData};
  assign full    = cfgFifoOff ? (count != '0) : (count == CNT_W'(DEPTH));
  assign doPush  = stb.rxPush & ~full;
  assign doPop   = rxRead & (count != '0);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      rxOverrun <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
      if (stb.rxPush && full) rxOverrun <= 1'b1;
      else if (doPop)         rxOverrun <= 1'b0;
    end
  end

  assign rxAvail = (count != '0);
  assign rxHead  = mem[rdPtr];

endmodule

// File: rtl/uart9_top.sv
module uart9_top
  import uart9_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int DIV_W      = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [DIV_W-1:0] cfgDivIn,
  input  logic             cfgSevenIn,
  input  logic             cfgXbitEnIn,
  input  logic             cfgFifoOffIn,
  output logic [DIV_W-1:0] cfgDivOut,
  output logic             cfgSevenOut,
  output logic             cfgXbitEnOut,
  output logic             cfgFifoOffOut,
  input  logic             txValid,
  input  logic [7:0]       txData,
  input  logic             txXbit,
  output logic             txBusy,
  output logic             serialOut,
  input  logic             serialIn,
  input  logic             rxRead,
  output logic             rxAvail,
  output logic [7:0]       rxData,
  output logic             rxXbit,
  output logic             rxFrameErr,
  output logic             rxOverrun
);

  ctrlStrobes_t stb;
  logic         lineSync;
  rxWord_t      rxHead;

  uart9_ctrl #(.OVS(OVS), .DIV_W(DIV_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWe        (cfgWe),
    .cfgDivIn     (cfgDivIn),
    .cfgSevenIn   (cfgSevenIn),
    .cfgXbitEnIn  (cfgXbitEnIn),
    .cfgFifoOffIn (cfgFifoOffIn),
    .cfgDiv       (cfgDivOut),
    .cfgSeven     (cfgSevenOut),
    .cfgXbitEn    (cfgXbitEnOut),
    .cfgFifoOff   (cfgFifoOffOut),
    .txValid      (txValid),
    .txBusy       (txBusy),
    .lineSync     (lineSync),
    .stb          (stb)
  );

  uart9_dp #(.DEPTH(FIFO_DEPTH), .SYNC_STAGES(2)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cfgSeven   (cfgSevenOut),
    .cfgXbitEn  (cfgXbitEnOut),
    .cfgFifoOff (cfgFifoOffOut),
    .txData     (txData),
    .txXbit     (txXbit),
    .serialOut  (serialOut),
    .serialIn   (serialIn),
    .lineSync   (lineSync),
    .rxRead     (rxRead),
    .rxAvail    (rxAvail),
    .rxHead     (rxHead),
    .rxOverrun  (rxOverrun)
  );

  assign rxData     = rxHead.data;
  assign rxXbit     = rxHead.xbit;
  assign rxFrameErr = rxHead.frameErr;

endmodule

// File: rtl/uart9_checker.sv
module uart9_checker #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [DIV_W-1:0] cfgDivOut,
  input logic             cfgSevenOut,
  input logic             cfgXbitEnOut,
  input logic             cfgFifoOffOut,
  input logic             txBusy,
  input logic             serialOut,
  input logic             rxRead,
  input logic             rxAvail,
  input logic             rxOverrun
);

  // R2: outside a frame the line rests high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> serialOut);

  // R2: a frame opens with a low start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !serialOut);

  // R1: configuration only moves on a write strobe
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable({cfgDivOut, cfgSevenOut, cfgXbitEnOut, cfgFifoOffOut}));

  // R8: held words leave only through a read
  p_avail_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxAvail) |-> $past(rxRead));

  // R8: overrun only rises when something was already held
  p_overrun_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxAvail));

endmodule

bind uart9_top uart9_checker #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_uart9_top.sv
module sim_uart9_top;

  localparam int CLK_P = 10;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             cfgWe;
  logic [DIV_W-1:0] cfgDivIn;
  logic             cfgSevenIn, cfgXbitEnIn, cfgFifoOffIn;
  logic [DIV_W-1:0] cfgDivOut;
  logic             cfgSevenOut, cfgXbitEnOut, cfgFifoOffOut;
  logic             txValid;
  logic [7:0]       txData;
  logic             txXbit;
  logic             txBusy, serialOut;
  logic             serialIn;
  logic             rxRead;
  logic             rxAvail;
  logic [7:0]       rxData;
  logic             rxXbit, rxFrameErr, rxOverrun;

  uart9_top u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgDivIn(cfgDivIn),
    .cfgSevenIn(cfgSevenIn), .cfgXbitEnIn(cfgXbitEnIn), .cfgFifoOffIn(cfgFifoOffIn),
    .cfgDivOut(cfgDivOut), .cfgSevenOut(cfgSevenOut), .cfgXbitEnOut(cfgXbitEnOut),
    .cfgFifoOffOut(cfgFifoOffOut), .txValid(txValid), .txData(txData), .txXbit(txXbit),
    .txBusy(txBusy), .serialOut(serialOut), .serialIn(serialIn), .rxRead(rxRead),
    .rxAvail(rxAvail), .rxData(rxData), .rxXbit(rxXbit), .rxFrameErr(rxFrameErr),
    .rxOverrun(rxOverrun)
  );

  always #(CLK_P / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // bench-side configuration copy
  int bDiv = 0;
  bit bSeven = 0, bX = 0, bOff = 0;

  // ---------------- transmit reference model ----------------
  int    txE = -1000000;
  int    txN = 0;
  int    txL = 16;
  logic  frBits [0:11];
  string txTag = "R2";
  bit    run = 0;

  function automatic bit mBusy();
    int m = cyc - txE;
    return (m >= 0) && (m < txN * txL);
  endfunction

  function automatic logic mOut();
    int m = cyc - txE;
    if (m >= 0 && m < txN * txL) return frBits[m / txL];
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (run && !finished) begin
      chk(serialOut === mOut(), txTag, int'(serialOut), int'(mOut()));
      chk(txBusy === mBusy(), txTag, int'(txBusy), int'(mBusy()));
    end
  end

  // ---------------- receive reference model ----------------
  logic [9:0] expQ [$];
  bit         expOvr = 0;

  task automatic cfgSet(input int dv, input bit sv, input bit xv, input bit ov);
    @(negedge clk);
    cfgDivIn = DIV_W'(dv); cfgSevenIn = sv; cfgXbitEnIn = xv; cfgFifoOffIn = ov;
    cfgWe = 1'b1;
    bDiv = dv; bSeven = sv; bX = xv; bOff = ov;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitTxIdle();
    @(negedge clk);
    while (mBusy()) @(negedge clk);
  endtask

  task automatic doTx(input logic [7:0] d, input logic x, input string tag);
    int nd;
    waitTxIdle();
    nd = bSeven ? 7 : 8;
    for (int i = 0; i < 12; i++) frBits[i] = 1'b1;
    frBits[0] = 1'b0;
    for (int i = 0; i < nd; i++) frBits[1 + i] = d[i];
    if (bX) frBits[1 + nd] = x;
    txN   = 2 + nd + (bX ? 1 : 0);
    txL   = 16 * (bDiv + 1);
    txTag = tag;
    txE   = cyc + 1;
    txData = d; txXbit = x; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] d, input logic x, input logic stopV);
    int nd = bSeven ? 7 : 8;
    int L  = 16 * (bDiv + 1);
    logic [9:0] w;
    @(negedge clk);
    serialIn = 1'b0;
    repeat (L) @(negedge clk);
    for (int i = 0; i < nd; i++) begin
      serialIn = d[i];
      repeat (L) @(negedge clk);
    end
    if (bX) begin
      serialIn = x;
      repeat (L) @(negedge clk);
    end
    serialIn = stopV;
    repeat (L) @(negedge clk);
    serialIn = 1'b1;
    repeat (L) @(negedge clk);
    w[7:0] = (nd == 7) ? {1'b0, d[6:0]} : d;
    w[8]   = bX ? x : 1'b0;
    w[9]   = ~stopV;
    if (expQ.size() < (bOff ? 1 : 8)) expQ.push_back(w);
    else expOvr = 1'b1;
  endtask

  task automatic rdCheck(input string tag);
    logic [9:0] w;
    @(negedge clk);
    chk(rxAvail === (expQ.size() != 0), tag, int'(rxAvail), int'(expQ.size() != 0));
    if (expQ.size() != 0) begin
      w = expQ[0];
      chk(rxData === w[7:0], tag, int'(rxData), int'(w[7:0]));
      chk(rxXbit === w[8], tag, int'(rxXbit), int'(w[8]));
      chk(rxFrameErr === w[9], tag, int'(rxFrameErr), int'(w[9]));
      rxRead = 1'b1;
      @(negedge clk);
      rxRead = 1'b0;
      void'(expQ.pop_front());
      expOvr = 1'b0;
    end
  endtask

  task automatic ovrCheck(input string tag);
    @(negedge clk);
    chk(rxOverrun === expOvr, tag, int'(rxOverrun), int'(expOvr));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgDivIn = '0; cfgSevenIn = 1'b0;
    cfgXbitEnIn = 1'b0; cfgFifoOffIn = 1'b0; txValid = 1'b0; txData = '0;
    txXbit = 1'b0; serialIn = 1'b1; rxRead = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk(cfgDivOut === '0, "R1", int'(cfgDivOut), 0);
    chk({cfgSevenOut, cfgXbitEnOut, cfgFifoOffOut} === 3'b000, "R1",
        int'({cfgSevenOut, cfgXbitEnOut, cfgFifoOffOut}), 0);
    chk(serialOut === 1'b1, "R2", int'(serialOut), 1);
    chk(rxAvail === 1'b0, "R8", int'(rxAvail), 0);
    chk(rxOverrun === 1'b0, "R8", int'(rxOverrun), 0);
    run = 1;

    // R1: readback of a written configuration
    cfgSet(1, 0, 0, 0);
    @(negedge clk);
    chk(cfgDivOut === 4'd1, "R1", int'(cfgDivOut), 1);

    // R2: plain 8-bit frame
    doTx(8'hA5, 1'b0, "R2");
    // R4 with extra bit disabled, and R10 mid-frame request
    doTx(8'h3C, 1'b1, "R10");
    repeat (40) @(negedge clk);
    txData = 8'h00; txXbit = 1'b0; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    waitTxIdle();

    // R3: seven bits, top bit of an all-ones byte ignored
    cfgSet(1, 1, 0, 0);
    doTx(8'hFF, 1'b0, "R3");
    // R4: seven bits with extra bit
    cfgSet(1, 1, 1, 0);
    doTx(8'h80, 1'b1, "R4");
    // R4: eight bits with extra bit both values
    cfgSet(2, 0, 1, 0);
    doTx(8'h5A, 1'b0, "R4");
    doTx(8'h00, 1'b1, "R4");
    waitTxIdle();

    // R5: 8-bit receive
    cfgSet(2, 0, 0, 0);
    rxSend(8'hC3, 1'b0, 1'b1);
    rdCheck("R5");
    // R6: extra bit captured with its word
    cfgSet(2, 0, 1, 0);
    rxSend(8'h96, 1'b1, 1'b1);
    rdCheck("R6");
    // R5: 7-bit receive, bit 7 reads 0, extra bit 0 sits where bit 7 would be
    cfgSet(1, 1, 1, 0);
    rxSend(8'hFF, 1'b0, 1'b1);
    rdCheck("R5");
    // R6: extra bit disabled reads 0
    cfgSet(1, 1, 0, 0);
    rxSend(8'h2B, 1'b1, 1'b1);
    rdCheck("R6");

    // R7: bad stop bit followed by a clean frame
    cfgSet(1, 0, 0, 0);
    rxSend(8'h81, 1'b0, 1'b0);
    rxSend(8'h7E, 1'b0, 1'b1);
    rdCheck("R7");
    rdCheck("R7");

    // R8: nine frames into eight slots
    cfgSet(0, 0, 1, 0);
    for (int i = 0; i < 9; i++) rxSend(8'(i * 29 + 3), i[0], 1'b1);
    ovrCheck("R8");
    rdCheck("R8");
    ovrCheck("R8");
    for (int i = 0; i < 7; i++) rdCheck("R8");
    rdCheck("R8");

    // R9: single holding register
    cfgSet(0, 0, 0, 1);
    rxSend(8'h11, 1'b0, 1'b1);
    rxSend(8'h22, 1'b0, 1'b1);
    ovrCheck("R9");
    rdCheck("R9");
    rdCheck("R9");
    ovrCheck("R9");

    // R1: full divisor code readback
    cfgSet(15, 1, 1, 1);
    @(negedge clk);
    chk(cfgDivOut === 4'hF, "R1", int'(cfgDivOut), 15);
    chk({cfgSevenOut, cfgXbitEnOut, cfgFifoOffOut} === 3'b111, "R1",
        int'({cfgSevenOut, cfgXbitEnOut, cfgFifoOffOut}), 7);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule